// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block paces the serial clock of an I2C controller. A free-running divider slows the system clock by a programmable factor to form a module tick. Two phase counters run on that tick. The high phase lasts a clamped prescale plus two ticks. The low phase lasts the same plus an extra low-only adjustment. The block drives an open-drain style SCL level and marks each edge with a one-cycle strobe, which the byte engine uses to shift data.

A target may stretch the clock by holding SCL low after the controller releases it. While that happens the high-phase count does not start. The divider is held at zero, so the high phase is timed from the moment the line is actually seen high.

A separate monitor counts consecutive system clocks during which SCL or SDA is sampled low. It raises a flag once the count reaches a programmed limit. The monitor can be switched off.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, and whenever `enable` is low, `scl_out` is 1 and neither strobe pulses. `timeout` is 0 after reset.
- R2: The module tick occurs once every (`clk_div` + 1) system clocks. Every phase length in system clocks is the tick count times (`clk_div` + 1).
- R3: With the bus following `scl_out`, the high phase lasts (P + 2) ticks, where P is the effective prescale.
- R4: The low phase lasts (P + `low_adj` + 2) ticks. The adjustment is never added to the high phase.
- R5: The effective prescale P is `prescale` clamped to at most 0xFD. Both 0xFE and 0xFF give P = 0xFD.
- R6: `rise_stb` pulses for one system clock in the cycle `scl_out` turns 1, and `fall_stb` in the cycle it turns 0. The two strobes never pulse together. The first edge after enabling is a fall.
- R7: After a rise, each system-clock edge at which `scl_in` is sampled low adds exactly one system clock to that high phase.
- R8: With `to_en` high, `timeout` is 1 once `scl_in` or `sda_in` has been sampled low at `to_limit` consecutive edges. It returns to 0 in the cycle after both lines are sampled high.
- R9: With `to_en` low, `timeout` stays 0 whatever the bus does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the SCL generator; low parks SCL high |
| clk_div | input | DIV_W | Module clock divider minus one |
| prescale | input | PS_W | Prescale shared by both phases (clamped) |
| low_adj | input | PS_W | Extra ticks added to the low phase only |
| to_en | input | 1 | Enable the bus-low timeout monitor |
| to_limit | input | TO_W | Low-hold limit in system clocks |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_out | output | 1 | SCL level driven by the controller (1 = released) |
| rise_stb | output | 1 | One-cycle pulse as SCL is released |
| fall_stb | output | 1 | One-cycle pulse as SCL is pulled low |
| timeout | output | 1 | SCL or SDA held low for the limit |

## Verification
Clock stretching and the timeout monitor act on the same SCL sample in the same cycle. When the stretching target lets go, the monitor clears its low count, and the held divider starts the high-phase count, both at one edge. The bench stretches a high phase for longer than the timeout limit. It checks that `timeout` is set just before the release and clear one cycle after it. The scoreboard then checks that the stretched high phase ends exactly the stretch length plus the nominal high time after the rise strobe. A second run with the monitor disabled repeats the stretch and expects no flag.

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int DIV_W = 4,
  parameter int PS_W  = 8,
  parameter int TO_W  = 16,
  parameter logic [PS_W-1:0] PS_MAX = 8'hFD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [PS_W-1:0]  prescale,
  input  logic [PS_W-1:0]  low_adj,
  input  logic             to_en,
  input  logic [TO_W-1:0]  to_limit,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_out,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             timeout
);
  localparam int CNT_W = PS_W + 2;

  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] ph_cnt;
  logic [TO_W-1:0]  scl_lo_cnt, sda_lo_cnt;

  logic [PS_W-1:0]  ps_eff;
  logic [CNT_W-1:0] high_len, low_len, ph_len;
  logic             stretched, tick, ph_last;

  assign ps_eff    = (prescale > PS_MAX) ? PS_MAX : prescale;
  assign high_len  = CNT_W'(ps_eff) + CNT_W'(2);
  assign low_len   = CNT_W'(ps_eff) + CNT_W'(low_adj) + CNT_W'(2);
  assign ph_len    = scl_out ? high_len : low_len;
  assign stretched = scl_out & ~scl_in;
  assign tick      = enable & ~stretched & (div_cnt >= clk_div);
  assign ph_last   = (ph_cnt >= ph_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (!enable || stretched || tick) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_out  <= 1'b1;
      ph_cnt   <= '0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else if (!enable) begin
      scl_out  <= 1'b1;
      ph_cnt   <= '0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      if (tick) begin
        if (ph_last) begin
          ph_cnt   <= '0;
          scl_out  <= ~scl_out;
          rise_stb <= ~scl_out;
          fall_stb <= scl_out;
        end else begin
          ph_cnt <= ph_cnt + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_lo_cnt <= '0;
      sda_lo_cnt <= '0;
    end else if (!to_en) begin
      scl_lo_cnt <= '0;
      sda_lo_cnt <= '0;
    end else begin
      if (scl_in)            scl_lo_cnt <= '0;
      else if (~&scl_lo_cnt) scl_lo_cnt <= scl_lo_cnt + TO_W'(1);
      if (sda_in)            sda_lo_cnt <= '0;
      else if (~&sda_lo_cnt) sda_lo_cnt <= sda_lo_cnt + TO_W'(1);
    end
  end

  assign timeout = to_en && (to_limit != '0) &&
                   ((scl_lo_cnt >= to_limit) || (sda_lo_cnt >= to_limit));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_out && !rise_stb && !fall_stb));

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  p_rise_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl_out && !$past(scl_out)));

  p_fall_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!scl_out && $past(scl_out)));

  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && scl_out && !scl_in) |=> !fall_stb);

  p_to_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && sda_in) |=> !timeout);

  p_to_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !to_en |=> !timeout);
endmodule

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [3:0]  clk_div = '0;
  logic [7:0]  prescale = '0;
  logic [7:0]  low_adj = '0;
  logic        to_en = 1'b0;
  logic [15:0] to_limit = '0;
  logic        stretch = 1'b0;
  logic        sda_in = 1'b1;
  logic        scl_in;
  logic        scl_out, rise_stb, fall_stb, timeout;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_cyc = 0;
  bit arm = 1'b0;
  bit done = 1'b0;
  int exp_gap[$];
  bit exp_rise[$];
  string exp_req[$];

  assign scl_in = scl_out & ~stretch;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_phase_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
    .prescale(prescale), .low_adj(low_adj), .to_en(to_en), .to_limit(to_limit),
    .scl_in(scl_in), .sda_in(sda_in), .scl_out(scl_out), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .timeout(timeout)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected edge intervals and compares them
  always @(negedge clk) begin
    cyc++;
    if (rise_stb || fall_stb) begin
      if (arm) begin
        arm = 1'b0;
        check("R6 first edge is fall", fall_stb, 1);
      end else if (exp_gap.size() != 0) begin
        int g;
        bit r;
        string q;
        g = exp_gap.pop_front();
        r = exp_rise.pop_front();
        q = exp_req.pop_front();
        check({q, " edge kind"}, rise_stb, r);
        check({q, " gap"}, cyc - last_cyc, g);
      end
      last_cyc = cyc;
    end
  end

  task automatic push(input bit r, input int g, input string q);
    exp_rise.push_back(r);
    exp_gap.push_back(g);
    exp_req.push_back(q);
  endtask

  task automatic wait_strobe(input bit r);
    do @(negedge clk); while (r ? !rise_stb : !fall_stb);
  endtask

  task automatic drain();
    while (exp_gap.size() != 0) @(negedge clk);
  endtask

  task automatic run_cfg(input int d, input int ps, input int adj, input int pe,
                         input int pairs, input string q);
    int lo, hi;
    clk_div = 4'(d); prescale = 8'(ps); low_adj = 8'(adj);
    lo = (pe + adj + 2) * (d + 1);
    hi = (pe + 2) * (d + 1);
    arm = 1'b1;
    for (int i = 0; i < pairs; i++) begin
      push(1'b1, lo, q);
      push(1'b0, hi, q);
    end
    @(negedge clk) enable = 1'b1;
    drain();
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_stretch(input bit ten, input int s, input string q);
    clk_div = 4'd1; prescale = 8'd1; low_adj = 8'd0;
    to_en = ten; to_limit = 16'd15;
    arm = 1'b1;
    @(negedge clk) enable = 1'b1;
    wait_strobe(1'b0);
    push(1'b1, 6, q);
    push(1'b0, s + 6, "R7 stretched high");
    push(1'b1, 6, q);
    push(1'b0, 6, q);
    stretch = 1'b1;
    wait_strobe(1'b1);
    repeat (s - 1) @(negedge clk);
    if (ten) check("R8 timeout during stretch", timeout, 1);
    else     check("R9 timeout disabled during stretch", timeout, 0);
    @(negedge clk) stretch = 1'b0;
    @(negedge clk);
    check("R8 timeout clears after release", timeout, 0);
    drain();
    enable = 1'b0;
    to_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset scl_out", scl_out, 1);
    check("R1 reset rise_stb", rise_stb, 0);
    check("R1 reset fall_stb", fall_stb, 0);
    check("R1 reset timeout", timeout, 0);

    n = 0;
    clk_div = 4'd0; prescale = 8'd0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rise_stb || fall_stb || !scl_out) n++;
    end
    check("R1 idle while disabled", n, 0);

    run_cfg(0, 0, 0, 0, 3, "R3 R4 minimum");
    run_cfg(3, 2, 5, 2, 3, "R2 R4 divide and low adjust");
    run_cfg(1, 4, 0, 4, 2, "R2 R3 symmetric");
    run_cfg(0, 8'hFF, 0, 8'hFD, 2, "R5 clamp 0xFF");
    run_cfg(0, 8'hFE, 2, 8'hFD, 2, "R5 clamp 0xFE");
    run_cfg(0, 8'hFD, 3, 8'hFD, 2, "R5 at limit");

    run_stretch(1'b1, 20, "R7 base");
    run_stretch(1'b0, 20, "R9 base");

    to_en = 1'b1; to_limit = 16'd10;
    @(negedge clk) sda_in = 1'b0;
    repeat (9) @(negedge clk);
    check("R8 sda below limit", timeout, 0);
    @(negedge clk);
    check("R8 sda at limit", timeout, 1);
    @(negedge clk) sda_in = 1'b1;
    @(negedge clk);
    check("R8 sda release", timeout, 0);
    to_en = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule